// File: doc/BRIEF.md
# MCTP-over-SMBus Packet Transmitter

This block turns a message, delivered in chunks by a message source, into one or more MCTP packets and sends each as an SMBus block-write frame toward a remote endpoint. It drives a byte-level I2C master (start with address, data bytes, stop). The block does not handle bit-level signalling, arbitration or clock stretching. A `go` pulse captures the addressing context for the whole message: the remote 7-bit address and EID, the local address and EID, the 3-bit message tag, the starting 2-bit packet sequence, and a control-response flag.

For each chunk the block asks the source for a length and SOM/EOM marks. It then issues the address phase, followed by seven header bytes, the payload pulled byte by byte from the source, and a PEC byte. It closes the frame with a stop. A zero-length chunk ends the message: the block drops its bus request and returns to idle. A NACK on any byte aborts the frame. The block then issues a stop, pulses `err` and goes idle. In control-response mode exactly one packet is sent with SOM and EOM both set, and the bus is released after it.

States: `ST_IDLE` (bus released, waiting for `go`), `ST_FETCH` (requesting the next chunk descriptor), `ST_START` (offering the address phase), `ST_SEND` (offering the byte at the current frame position), `ST_WAIT` (waiting for the target's ACK/NACK), `ST_STOP` (offering the stop that closes a good frame) and `ST_ABORT` (offering the stop after a NACK).

Transitions:
- IDLE→FETCH on `go`.
- FETCH→IDLE on a zero-length chunk, and FETCH→START otherwise.
- START→WAIT and SEND→WAIT when the command is accepted.
- WAIT→ABORT on NACK.
- WAIT→STOP on ACK of the PEC byte.
- WAIT→SEND on any other ACK.
- STOP→FETCH, or STOP→IDLE in control mode.
- ABORT→IDLE.

Top module: `mctp_smbus_tx`

## Requirements
- R1: After reset `bus_req`, `src_req`, `m_valid`, `pl_ready` and `err` are all 0. While `bus_req` is 0, no command and no source request is issued.
- R2: A frame is sent in this order:
  - START with `m_kind`=0 and `m_data`={0, remote address};
  - DATA bytes (`m_kind`=1): 0x0F, byte count, {local address, 1}, 0x01, remote EID, local EID, flags, payload, PEC;
  - STOP (`m_kind`=2).
- R3: The byte count equals the packet's payload length plus 5.
- R4: The flags byte is {SOM, EOM, seq[1:0], 0, tag[2:0]}: bit 7 SOM, bit 6 EOM, bits 5:4 sequence, bits 2:0 message tag.
- R5: The first packet of a message carries `seq_init`. Each completed packet advances the sequence by one, wrapping modulo 4.
- R6: PEC is CRC-8 with polynomial 0x07 and initial value 0. It covers every earlier byte of the frame, starting with the address byte {remote address, 0}.
- R7: A chunk length above MAX_PAYLOAD is clamped to MAX_PAYLOAD. Only the clamped number of payload bytes is pulled, and the byte count reflects the clamped length.
- R8: In control-response mode the single packet has SOM and EOM set whatever the source reports. No further chunk is requested, and the bus is released after its stop.
- R9: A zero-length chunk produces no START. It drops `bus_req` and returns the block to idle.
- R10: A NACK on the address or any data byte stops the frame: no further byte is offered, one STOP follows, `err` pulses for one cycle and `bus_req` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start a message; context captured when idle |
| ctl_mode | input | 1 | Message is a control response (single packet) |
| own_addr | input | 7 | Local 7-bit SMBus address |
| own_eid | input | 8 | Local endpoint ID |
| peer_addr | input | 7 | Remote 7-bit SMBus address |
| peer_eid | input | 8 | Remote endpoint ID |
| msg_tag | input | 3 | Message tag stamped into flags |
| seq_init | input | 2 | Starting packet sequence |
| bus_req | output | 1 | Block owns the bus (high while not idle) |
| src_req | output | 1 | Request for the next chunk descriptor |
| src_rsp_valid | input | 1 | Chunk descriptor valid |
| src_len | input | LEN_W | Chunk payload length |
| src_som | input | 1 | Chunk starts the message |
| src_eom | input | 1 | Chunk ends the message |
| pl_valid | input | 1 | Payload byte valid |
| pl_data | input | 8 | Payload byte |
| pl_ready | output | 1 | Payload byte taken |
| m_valid | output | 1 | Master command valid |
| m_kind | output | 2 | Command: 0 START, 1 DATA, 2 STOP |
| m_data | output | 8 | START: {0, address}; DATA: byte |
| m_ready | input | 1 | Master accepts command |
| m_resp_valid | input | 1 | ACK/NACK result for last START or DATA |
| m_resp_nack | input | 1 | Result was NACK |
| err | output | 1 | One-cycle pulse on a NACK abort |

## Verification
The bench builds the block with MAX_PAYLOAD set to 8 instead of 250. With that value a chunk of 12 bytes exercises the clamp, the payload split and the byte-count adjustment in a short run. A three-chunk message starting at sequence 3 reaches the modulo-4 wrap. A NACK is injected on a mid-frame data byte to drive the abort path. The control-response case offers a second chunk, which must stay unrequested.

// File: rtl/mstx_pkg.sv
package mstx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_START,
        ST_SEND,
        ST_WAIT,
        ST_STOP,
        ST_ABORT
    } mstx_state_e;

    localparam logic [1:0] CMD_START = 2'd0;
    localparam logic [1:0] CMD_DATA  = 2'd1;
    localparam logic [1:0] CMD_STOP  = 2'd2;

    localparam logic [7:0] SMB_MCTP_CMD  = 8'h0F;
    localparam logic [7:0] MCTP_HDR_VER  = 8'h01;
    localparam int         HDR_BYTES     = 8;   // address byte + 7 header bytes
    localparam logic [7:0] COUNT_BIAS    = 8'd5;

    // one byte of a CRC-8, MSB first, no reflection
    function automatic logic [7:0] crc8_step(input logic [7:0] crc,
                                             input logic [7:0] b,
                                             input logic [7:0] poly);
        logic [7:0] c;
        c = crc ^ b;
        for (int i = 0; i < 8; i++) begin
            c = c[7] ? ((c << 1) ^ poly) : (c << 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/mstx_crc8.sv
module mstx_crc8 #(
    parameter logic [7:0] POLY = 8'h07
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       update,
    input  logic [7:0] din,
    output logic [7:0] crc
);
    import mstx_pkg::*;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            crc <= 8'h00;
        end else if (update) begin
            crc <= crc8_step(crc, din, POLY);
        end
    end

endmodule

// File: rtl/mstx_seq.sv
module mstx_seq #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] init,
    input  logic         step,
    output logic [W-1:0] seq
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq <= '0;
        end else if (load) begin
            seq <= init;
        end else if (step) begin
            seq <= seq + W'(1);
        end
    end

endmodule

// File: rtl/mstx_frame_mux.sv
module mstx_frame_mux #(
    parameter int POS_W = 9
) (
    input  logic [POS_W-1:0] pos,
    input  logic [POS_W-1:0] len,
    input  logic [6:0]       peer_addr,
    input  logic [6:0]       own_addr,
    input  logic [7:0]       peer_eid,
    input  logic [7:0]       own_eid,
    input  logic [7:0]       flags,
    input  logic [7:0]       pl_byte,
    input  logic [7:0]       pec,
    output logic [7:0]       frame_byte,
    output logic             is_payload,
    output logic             is_last
);
    import mstx_pkg::*;

    localparam logic [POS_W-1:0] FIRST_PL = POS_W'(HDR_BYTES);

    logic [POS_W-1:0] end_pos;

    always_comb begin
        end_pos    = len + FIRST_PL;
        is_payload = (pos >= FIRST_PL) && (pos < end_pos);
        is_last    = (pos == end_pos);
        if (pos == POS_W'(0))      frame_byte = {peer_addr, 1'b0};
        else if (pos == POS_W'(1)) frame_byte = SMB_MCTP_CMD;
        else if (pos == POS_W'(2)) frame_byte = 8'(len) + COUNT_BIAS;
        else if (pos == POS_W'(3)) frame_byte = {own_addr, 1'b1};
        else if (pos == POS_W'(4)) frame_byte = MCTP_HDR_VER;
        else if (pos == POS_W'(5)) frame_byte = peer_eid;
        else if (pos == POS_W'(6)) frame_byte = own_eid;
        else if (pos == POS_W'(7)) frame_byte = flags;
        else if (is_payload)       frame_byte = pl_byte;
        else                       frame_byte = pec;
    end

endmodule

// File: rtl/mctp_smbus_tx.sv
module mctp_smbus_tx #(
    parameter int MAX_PAYLOAD = 250,
    parameter int LEN_W       = 8,
    parameter int POS_W       = $clog2(MAX_PAYLOAD + 9)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             ctl_mode,
    input  logic [6:0]       own_addr,
    input  logic [7:0]       own_eid,
    input  logic [6:0]       peer_addr,
    input  logic [7:0]       peer_eid,
    input  logic [2:0]       msg_tag,
    input  logic [1:0]       seq_init,
    output logic             bus_req,
    output logic             src_req,
    input  logic             src_rsp_valid,
    input  logic [LEN_W-1:0] src_len,
    input  logic             src_som,
    input  logic             src_eom,
    input  logic             pl_valid,
    input  logic [7:0]       pl_data,
    output logic             pl_ready,
    output logic             m_valid,
    output logic [1:0]       m_kind,
    output logic [7:0]       m_data,
    input  logic             m_ready,
    input  logic             m_resp_valid,
    input  logic             m_resp_nack,
    output logic             err
);
    import mstx_pkg::*;

    localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_PAYLOAD);

    mstx_state_e state, state_nx;

    logic [6:0]       c_peer_addr, c_own_addr;
    logic [7:0]       c_peer_eid, c_own_eid;
    logic [2:0]       c_tag;
    logic             c_ctl;
    logic [POS_W-1:0] len_q, pos;
    logic             som_q, eom_q;

    logic [1:0] seq;
    logic [7:0] crc, frame_byte, flags;
    logic       is_payload, is_last;
    logic       go_take, chunk_take, resp_ok, cmd_take;
    logic       seq_step, crc_upd;
    logic [POS_W-1:0] len_clamp;

    assign go_take    = (state == ST_IDLE) && go;
    assign chunk_take = (state == ST_FETCH) && src_rsp_valid;
    assign resp_ok    = (state == ST_WAIT) && m_resp_valid && !m_resp_nack;
    assign cmd_take   = m_valid && m_ready;
    assign seq_step   = (state == ST_STOP) && m_ready;
    assign crc_upd    = cmd_take && ((state == ST_START) || (state == ST_SEND && !is_last));
    assign len_clamp  = (src_len > MAX_L) ? POS_W'(MAX_L) : POS_W'(src_len);
    assign flags      = {som_q | c_ctl, eom_q | c_ctl, seq, 1'b0, c_tag};

    mstx_seq #(.W(2)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (go_take),
        .init  (seq_init),
        .step  (seq_step),
        .seq   (seq)
    );

    mstx_crc8 #(.POLY(8'h07)) u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (chunk_take),
        .update (crc_upd),
        .din    (frame_byte),
        .crc    (crc)
    );

    mstx_frame_mux #(.POS_W(POS_W)) u_mux (
        .pos        (pos),
        .len        (len_q),
        .peer_addr  (c_peer_addr),
        .own_addr   (c_own_addr),
        .peer_eid   (c_peer_eid),
        .own_eid    (c_own_eid),
        .flags      (flags),
        .pl_byte    (pl_data),
        .pec        (crc),
        .frame_byte (frame_byte),
        .is_payload (is_payload),
        .is_last    (is_last)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (go) state_nx = ST_FETCH;
            ST_FETCH: if (src_rsp_valid)
                          state_nx = (len_clamp == '0) ? ST_IDLE : ST_START;
            ST_START: if (m_ready) state_nx = ST_WAIT;
            ST_SEND:  if (cmd_take) state_nx = ST_WAIT;
            ST_WAIT:  if (m_resp_valid) begin
                          if (m_resp_nack)  state_nx = ST_ABORT;
                          else if (is_last) state_nx = ST_STOP;
                          else              state_nx = ST_SEND;
                      end
            ST_STOP:  if (m_ready) state_nx = c_ctl ? ST_IDLE : ST_FETCH;
            ST_ABORT: if (m_ready) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        bus_req  = (state != ST_IDLE);
        src_req  = 1'b0;
        m_valid  = 1'b0;
        m_kind   = CMD_DATA;
        m_data   = frame_byte;
        pl_ready = 1'b0;
        unique case (state)
            ST_IDLE, ST_WAIT: ;
            ST_FETCH: src_req = 1'b1;
            ST_START: begin
                m_valid = 1'b1;
                m_kind  = CMD_START;
                m_data  = {1'b0, c_peer_addr};
            end
            ST_SEND: begin
                m_valid  = is_payload ? pl_valid : 1'b1;
                pl_ready = is_payload && m_ready;
            end
            ST_STOP, ST_ABORT: begin
                m_valid = 1'b1;
                m_kind  = CMD_STOP;
                m_data  = 8'h00;
            end
            default: ;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_peer_addr <= '0;
            c_own_addr  <= '0;
            c_peer_eid  <= '0;
            c_own_eid   <= '0;
            c_tag       <= '0;
            c_ctl       <= 1'b0;
            len_q       <= '0;
            som_q       <= 1'b0;
            eom_q       <= 1'b0;
            pos         <= '0;
            err         <= 1'b0;
        end else begin
            err <= (state == ST_WAIT) && m_resp_valid && m_resp_nack;
            if (go_take) begin
                c_peer_addr <= peer_addr;
                c_own_addr  <= own_addr;
                c_peer_eid  <= peer_eid;
                c_own_eid   <= own_eid;
                c_tag       <= msg_tag;
                c_ctl       <= ctl_mode;
            end
            if (chunk_take) begin
                len_q <= len_clamp;
                som_q <= src_som;
                eom_q <= src_eom;
                pos   <= '0;
            end else if (resp_ok && !is_last) begin
                pos <= pos + POS_W'(1);
            end
        end
    end

endmodule

// File: rtl/mstx_checker.sv
module mstx_checker #(
    parameter int MAX_PAYLOAD = 250,
    parameter int POS_W       = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_req,
    input logic             src_req,
    input logic             pl_ready,
    input logic             m_valid,
    input logic [1:0]       m_kind,
    input logic [7:0]       m_data,
    input logic             m_ready,
    input logic             err,
    input logic             seq_load,
    input logic [1:0]       seq,
    input logic [POS_W-1:0] len_q
);
    import mstx_pkg::*;

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |-> (!m_valid && !src_req && !pl_ready));

    p_cmd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready && m_kind != CMD_DATA) |=>
            (m_valid && $stable(m_kind) && $stable(m_data)));

    // R5: sequence only moves on a go or on an accepted stop
    p_seq_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(seq) |-> ($past(seq_load) ||
            $past(m_valid && m_ready && m_kind == CMD_STOP)));

    p_len_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        len_q <= POS_W'(MAX_PAYLOAD));

    p_pl_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pl_ready |-> (m_kind == CMD_DATA && m_ready));

    p_src_owned_r9: assert property (@(posedge clk) disable iff (!rst_n)
        src_req |-> bus_req);

    p_err_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    p_err_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (m_valid && m_kind == CMD_STOP));

endmodule

bind mctp_smbus_tx mstx_checker #(.MAX_PAYLOAD(MAX_PAYLOAD), .POS_W(POS_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_req  (bus_req),
    .src_req  (src_req),
    .pl_ready (pl_ready),
    .m_valid  (m_valid),
    .m_kind   (m_kind),
    .m_data   (m_data),
    .m_ready  (m_ready),
    .err      (err),
    .seq_load (go_take),
    .seq      (seq),
    .len_q    (len_q)
);

// File: tb/tb_mctp_smbus_tx.sv
module tb_mctp_smbus_tx;

    localparam int MAXP  = 8;
    localparam int LEN_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic             go = 0, ctl_mode = 0;
    logic [6:0]       own_addr = 7'h1D, peer_addr = 7'h00;
    logic [7:0]       own_eid = 8'h09, peer_eid = 8'h00;
    logic [2:0]       msg_tag = 0;
    logic [1:0]       seq_init = 0;
    logic             bus_req, src_req, pl_ready, m_valid, err;
    logic             src_rsp_valid = 0, src_som = 0, src_eom = 0;
    logic [LEN_W-1:0] src_len = 0;
    logic             pl_valid = 1;
    logic [7:0]       pl_data;
    logic [1:0]       m_kind;
    logic [7:0]       m_data;
    logic             m_ready = 1, m_resp_valid = 0, m_resp_nack = 0;

    mctp_smbus_tx #(.MAX_PAYLOAD(MAXP), .LEN_W(LEN_W)) dut (
        .clk(clk), .rst_n(rst_n), .go(go), .ctl_mode(ctl_mode),
        .own_addr(own_addr), .own_eid(own_eid), .peer_addr(peer_addr),
        .peer_eid(peer_eid), .msg_tag(msg_tag), .seq_init(seq_init),
        .bus_req(bus_req), .src_req(src_req), .src_rsp_valid(src_rsp_valid),
        .src_len(src_len), .src_som(src_som), .src_eom(src_eom),
        .pl_valid(pl_valid), .pl_data(pl_data), .pl_ready(pl_ready),
        .m_valid(m_valid), .m_kind(m_kind), .m_data(m_data), .m_ready(m_ready),
        .m_resp_valid(m_resp_valid), .m_resp_nack(m_resp_nack), .err(err)
    );

    int total = 0, fails = 0;

    // stimulus and observation state
    int         ch_n = 0, ci = 0;
    int         ch_len [0:7];
    bit         ch_som [0:7];
    bit         ch_eom [0:7];
    int         pl_idx = 0, err_cnt = 0, log_n = 0, nack_at = -1;
    bit         pl_hs = 0, resp_pend = 0;
    int         resp_idx = 0;
    logic [9:0] log_e [0:255];
    logic [9:0] exp_e [0:255];
    string      exp_t [0:255];
    int         exp_n = 0;

    function automatic logic [7:0] pay(input int i);
        return 8'(i * 37 + 11);
    endfunction

    function automatic logic [7:0] crc_ref(input logic [7:0] c, input logic [7:0] b);
        logic [7:0] r;
        r = c ^ b;
        for (int k = 0; k < 8; k++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    // bus target, payload source and chunk source models
    initial begin
        pl_data = pay(0);
        forever begin
            @(negedge clk);
            if (err) err_cnt++;
            m_resp_valid = 0;
            m_resp_nack  = 0;
            if (resp_pend) begin
                m_resp_valid = 1;
                m_resp_nack  = (resp_idx == nack_at);
                resp_pend    = 0;
            end
            if (m_valid && m_ready) begin
                if (log_n < 256) log_e[log_n] = {m_kind, m_data};
                if (m_kind != 2'd2) begin resp_pend = 1; resp_idx = log_n; end
                log_n++;
            end
            if (pl_hs) begin pl_idx++; pl_hs = 0; end
            if (pl_ready && pl_valid) pl_hs = 1;
            pl_data = pay(pl_idx);
            if (src_rsp_valid) begin
                src_rsp_valid = 0;
                ci++;
            end else if (src_req) begin
                src_rsp_valid = 1;
                src_len = (ci < ch_n) ? LEN_W'(ch_len[ci]) : '0;
                src_som = (ci < ch_n) ? ch_som[ci] : 1'b0;
                src_eom = (ci < ch_n) ? ch_eom[ci] : 1'b0;
            end
        end
    end

    task automatic add_exp(input logic [1:0] k, input logic [7:0] d, input string t);
        exp_e[exp_n] = {k, d};
        exp_t[exp_n] = t;
        exp_n++;
    endtask

    task automatic build_expected(input bit ctl);
        logic [1:0] sq;
        logic [7:0] c, b;
        int p;
        sq = seq_init;
        p = 0;
        exp_n = 0;
        for (int k = 0; k < ch_n; k++) begin
            int clen;
            if (ch_len[k] == 0) break;
            clen = (ch_len[k] > MAXP) ? MAXP : ch_len[k];
            add_exp(2'd0, {1'b0, peer_addr}, "R2");
            c = crc_ref(8'h00, {peer_addr, 1'b0});
            for (int j = 0; j < 7 + clen; j++) begin
                string t;
                t = "R2";
                case (j)
                    0: b = 8'h0F;
                    1: begin b = 8'(clen + 5); t = "R3"; end
                    2: b = {own_addr, 1'b1};
                    3: b = 8'h01;
                    4: b = peer_eid;
                    5: b = own_eid;
                    6: begin
                        b = {ctl | ch_som[k], ctl | ch_eom[k], sq, 1'b0, msg_tag};
                        t = ctl ? "R8" : "R4 R5";
                    end
                    default: begin
                        b = pay(p);
                        p++;
                        if (ch_len[k] > MAXP) t = "R7";
                    end
                endcase
                add_exp(2'd1, b, t);
                c = crc_ref(c, b);
            end
            add_exp(2'd1, c, "R6");
            add_exp(2'd2, 8'h00, "R2");
            sq = sq + 2'd1;
            if (ctl) break;
        end
    endtask

    task automatic run_msg(input logic [6:0] pa, input logic [7:0] pe,
                           input logic [2:0] tg, input logic [1:0] si, input bit ctl);
        @(negedge clk);
        log_n = 0; ci = 0; pl_idx = 0; err_cnt = 0;
        peer_addr = pa; peer_eid = pe; msg_tag = tg; seq_init = si; ctl_mode = ctl;
        go = 1;
        @(negedge clk);
        go = 0;
        while (bus_req) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic compare_log();
        check(log_n == exp_n, "R2 command count", log_n, exp_n);
        for (int i = 0; i < exp_n && i < log_n; i++)
            check(log_e[i] == exp_e[i], exp_t[i], log_e[i], exp_e[i]);
    endtask

    task automatic t_reset();
        check(bus_req == 0 && src_req == 0 && m_valid == 0 && pl_ready == 0 && err == 0,
              "R1 reset outputs", {bus_req, src_req, m_valid, pl_ready, err}, 0);
    endtask

    // R2..R6 and R5 wrap: three chunks from sequence 3
    task automatic t_multi();
        ch_n = 4;
        ch_len[0] = 3; ch_som[0] = 1; ch_eom[0] = 0;
        ch_len[1] = 5; ch_som[1] = 0; ch_eom[1] = 0;
        ch_len[2] = 2; ch_som[2] = 0; ch_eom[2] = 1;
        ch_len[3] = 0; ch_som[3] = 0; ch_eom[3] = 0;
        run_msg(7'h2A, 8'h21, 3'd5, 2'd3, 0);
        build_expected(0);
        compare_log();
        check(bus_req == 0, "R9 release after zero chunk", bus_req, 0);
        check(ci == 4, "R9 chunks fetched", ci, 4);
    endtask

    // R7: clamp
    task automatic t_clamp();
        ch_n = 2;
        ch_len[0] = 12; ch_som[0] = 1; ch_eom[0] = 1;
        ch_len[1] = 0;  ch_som[1] = 0; ch_eom[1] = 0;
        run_msg(7'h51, 8'h33, 3'd2, 2'd0, 0);
        build_expected(0);
        compare_log();
        check(pl_idx == MAXP, "R7 payload bytes pulled", pl_idx, MAXP);
    endtask

    // R8: control response
    task automatic t_ctl();
        ch_n = 2;
        ch_len[0] = 4; ch_som[0] = 0; ch_eom[0] = 0;
        ch_len[1] = 3; ch_som[1] = 0; ch_eom[1] = 1;
        run_msg(7'h10, 8'h44, 3'd1, 2'd2, 1);
        build_expected(1);
        compare_log();
        check(ci == 1, "R8 chunks fetched", ci, 1);
        check(bus_req == 0, "R8 bus released", bus_req, 0);
    endtask

    // R9: zero length first chunk
    task automatic t_zero();
        ch_n = 1;
        ch_len[0] = 0; ch_som[0] = 1; ch_eom[0] = 1;
        run_msg(7'h33, 8'h55, 3'd0, 2'd0, 0);
        check(log_n == 0, "R9 no command issued", log_n, 0);
        check(bus_req == 0 && ci == 1, "R9 idle after zero chunk", {bus_req, 8'(ci)}, 1);
    endtask

    // R10: NACK on a mid-frame data byte (command index 5)
    task automatic t_nack();
        ch_n = 2;
        ch_len[0] = 4; ch_som[0] = 1; ch_eom[0] = 1;
        ch_len[1] = 0; ch_som[1] = 0; ch_eom[1] = 0;
        nack_at = 5;
        run_msg(7'h6E, 8'h12, 3'd3, 2'd1, 0);
        nack_at = -1;
        build_expected(0);
        exp_n = 7;
        exp_e[6] = {2'd2, 8'h00};
        exp_t[6] = "R10";
        compare_log();
        check(err_cnt == 1, "R10 err pulses", err_cnt, 1);
        check(bus_req == 0 && ci == 1, "R10 idle after abort", {bus_req, 8'(ci)}, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1;
        repeat (2) @(negedge clk);
        t_multi();
        t_clamp();
        t_ctl();
        t_zero();
        t_nack();
        t_multi();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule